// File: doc/BRIEF.md
# Sync-Gated Block Buffer Controller

This block decides which received data blocks are committed to a local circular block memory, based on the frame synchronization state reported by an external detector. Before synchronization is established, incoming blocks are held in a small backward-protection window. Once sync is reported, that window is committed to memory first, and blocks that arrive later are appended behind it in arrival order. A write-mode bit allows unsynchronized blocks to be committed as well.

A synchronization reset can come from a register bit or from an input pin. Either source forces the unsynchronized state, discards the window, rewinds the memory pointers and clears the stored-block count. Software is expected to issue this reset after every channel change, so that no stale blocks survive.

A consumer drains blocks through a one-block-per-cycle read port. An active-low ready line tells the consumer when enough unread blocks are waiting. The memory write port is brought out so that commits can be observed directly.

Top module: `sbb_top`

## Requirements
- R1: While rst_ni is low, and after it is released, ready_n_o is 1, mem_we_o is 0, ovf_o is 0 and rd_valid_o is 0.
- R2: The synchronization reset is sreset_bit_i OR sreset_pin_i. While it is 1, no block is written. Releasing it leaves the stored-block count at 0 (ready_n_o is 1), ovf_o at 0, the backward window empty, and the next write lands at mem_waddr_o = 0.
- R3: Blocks that arrive while the sync reset is held are discarded, even if sync_ok_i is 1. A block that arrives in the first cycle after release, with sync_ok_i = 1, is written at once.
- R4: With wr_all_i = 0 and sync_ok_i = 0, arriving blocks are not written. The window keeps the BP_DEPTH most recent of them (default 2) and drops older ones.
- R5: When commits are enabled and the window is not empty, one window entry is written per cycle, oldest first. Blocks arriving meanwhile are queued behind it, so memory receives blocks in arrival order.
- R6: With wr_all_i = 1 and the sync reset inactive, unsynchronized blocks are written.
- R7: ready_n_o is 0 exactly when the unread count is at or above the threshold chosen by thr_sel_i: {bit1,bit0} = 00 gives 1, 01 gives 4, 10 gives 8, 11 gives 12.
- R8: If rd_en_i is 1 and the count is nonzero, the oldest stored block appears on rd_data_o with rd_valid_o = 1 in the next cycle, and the count drops by one. If rd_en_i is 1 while the buffer is empty, rd_valid_o stays 0.
- R9: A commit attempted while MEM_DEPTH blocks are stored is dropped (mem_we_o = 0). This sets ovf_o, which stays 1 until a sync reset.
- R10: The write address advances by one per write and wraps from MEM_DEPTH-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| blk_valid_i | input | 1 | A decoded block is presented this cycle |
| blk_data_i | input | DATA_W | Block payload |
| sync_ok_i | input | 1 | Sync established (from external detector) |
| sreset_bit_i | input | 1 | Sync reset, register source |
| sreset_pin_i | input | 1 | Sync reset, pin source |
| wr_all_i | input | 1 | 1: also commit unsynchronized blocks |
| thr_sel_i | input | 2 | Ready threshold select |
| rd_en_i | input | 1 | Read one stored block |
| mem_we_o | output | 1 | Memory write strobe |
| mem_waddr_o | output | $clog2(MEM_DEPTH) | Memory write address |
| mem_wdata_o | output | DATA_W | Memory write data |
| rd_valid_o | output | 1 | rd_data_o holds a block read last cycle |
| rd_data_o | output | DATA_W | Read block |
| ready_n_o | output | 1 | Low when the unread count reaches the threshold |
| ovf_o | output | 1 | Sticky: a commit was dropped because memory was full |

## Verification
The central case is the hand-off from unsynchronized to synchronized reception. Three blocks arrive before sync, then sync rises together with a fourth block. The bench expects the second and third blocks followed by the fourth, written at addresses 0, 1 and 2. A design with a shallow window, an inverted drain order, or direct commits that jump the queue writes them in the wrong order or loses one. The cycle right after sync reset release is also probed, along with blocks arriving while the reset is held with sync asserted. A design that restarts capture late, or accepts blocks during the reset, misses or gains a write. Each threshold setting is checked one block below and at its level, which catches swapped select bits. Filling the memory checks the dropped commit, the sticky overflow flag and the pointer wrap. The overflow flag is then cleared by a sync reset.

// File: rtl/sbb_pkg.sv
package sbb_pkg;
  // threshold for the ready line, sel = {bit1, bit0}
  function automatic int unsigned thr_of(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 12;
    endcase
  endfunction
endpackage

// File: rtl/sbb_bp_window.sv
module sbb_bp_window #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 2,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] head_o,
  output logic              empty_o
);
  logic [DATA_W-1:0] ent_q [DEPTH];
  logic [DATA_W-1:0] up    [DEPTH];
  logic [CW-1:0]     cnt_q;
  logic              full, shift;
  logic [CW-1:0]     base;

  assign full    = cnt_q == CW'(DEPTH);
  // a push into a full window evicts the oldest entry
  assign shift   = pop_i | (push_i & full);
  assign base    = shift ? cnt_q - 1'b1 : cnt_q;
  assign head_o  = ent_q[0];
  assign empty_o = cnt_q == '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (flush_i) cnt_q <= '0;
    else              cnt_q <= base + CW'(push_i);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    if (i < DEPTH - 1) begin : g_mid
      assign up[i] = ent_q[i+1];
    end else begin : g_last
      assign up[i] = '0;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ent_q[i] <= '0;
      else if (!flush_i) begin
        if (push_i && base == CW'(i)) ent_q[i] <= data_i;
        else if (shift)               ent_q[i] <= up[i];
      end
    end
  end

  p_pop_nonempty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  p_depth_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  p_flush_empties_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/sbb_ram.sv
module sbb_ram #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/sbb_thresh.sv
module sbb_thresh #(
  parameter int CW = 5
) (
  input  logic [1:0]    sel_i,
  input  logic [CW-1:0] cnt_i,
  output logic          ready_n_o
);
  import sbb_pkg::*;
  logic [CW-1:0] thr;

  assign thr       = CW'(thr_of(sel_i));
  assign ready_n_o = !(cnt_i >= thr);
endmodule

// File: rtl/sbb_top.sv
module sbb_top #(
  parameter int DATA_W    = 16,
  parameter int MEM_DEPTH = 16,
  parameter int BP_DEPTH  = 2,
  localparam int AW       = $clog2(MEM_DEPTH),
  localparam int CW       = $clog2(MEM_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              blk_valid_i,
  input  logic [DATA_W-1:0] blk_data_i,
  input  logic              sync_ok_i,
  input  logic              sreset_bit_i,
  input  logic              sreset_pin_i,
  input  logic              wr_all_i,
  input  logic [1:0]        thr_sel_i,
  input  logic              rd_en_i,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_waddr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              ready_n_o,
  output logic              ovf_o
);
  logic              srst, commit_en, arrive;
  logic              win_push, win_pop, win_empty;
  logic [DATA_W-1:0] win_head, wr_data;
  logic              wr_req, wr_do, rd_ok, full;
  logic [AW-1:0]     wptr_q, rptr_q;
  logic [CW-1:0]     cnt_q;
  logic              ovf_q, rd_valid_q;

  assign srst      = sreset_bit_i | sreset_pin_i;
  assign commit_en = (sync_ok_i | wr_all_i) & ~srst;
  assign arrive    = blk_valid_i & ~srst;

  // drain the window before any new arrival is committed
  assign win_pop  = commit_en & ~win_empty;
  assign win_push = arrive & (~commit_en | ~win_empty);
  assign wr_req   = win_pop | (commit_en & arrive & win_empty);
  assign wr_data  = win_pop ? win_head : blk_data_i;

  assign full  = cnt_q == CW'(MEM_DEPTH);
  assign wr_do = wr_req & ~full;
  assign rd_ok = rd_en_i & (cnt_q != '0) & ~srst;

  sbb_bp_window #(.DATA_W(DATA_W), .DEPTH(BP_DEPTH)) u_win (
    .clk_i, .rst_ni,
    .flush_i (srst),
    .push_i  (win_push),
    .pop_i   (win_pop),
    .data_i  (blk_data_i),
    .head_o  (win_head),
    .empty_o (win_empty)
  );

  sbb_ram #(.DATA_W(DATA_W), .DEPTH(MEM_DEPTH)) u_ram (
    .clk_i, .rst_ni,
    .we_i    (wr_do),
    .waddr_i (wptr_q),
    .wdata_i (wr_data),
    .re_i    (rd_ok),
    .raddr_i (rptr_q),
    .rdata_o (rd_data_o)
  );

  sbb_thresh #(.CW(CW)) u_thr (
    .sel_i     (thr_sel_i),
    .cnt_i     (cnt_q),
    .ready_n_o (ready_n_o)
  );

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(MEM_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q     <= '0;
      rptr_q     <= '0;
      cnt_q      <= '0;
      ovf_q      <= 1'b0;
      rd_valid_q <= 1'b0;
    end else if (srst) begin
      wptr_q     <= '0;
      rptr_q     <= '0;
      cnt_q      <= '0;
      ovf_q      <= 1'b0;
      rd_valid_q <= 1'b0;
    end else begin
      if (wr_do) wptr_q <= nxt(wptr_q);
      if (rd_ok) rptr_q <= nxt(rptr_q);
      cnt_q      <= cnt_q + CW'(wr_do) - CW'(rd_ok);
      if (wr_req && full) ovf_q <= 1'b1;
      rd_valid_q <= rd_ok;
    end
  end

  assign mem_we_o    = wr_do;
  assign mem_waddr_o = wptr_q;
  assign mem_wdata_o = wr_data;
  assign rd_valid_o  = rd_valid_q;
  assign ovf_o       = ovf_q;

  p_no_write_in_reset_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sreset_bit_i || sreset_pin_i) |-> !mem_we_o);
  p_ready_high_after_reset_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sreset_bit_i || sreset_pin_i) |=> ready_n_o && !ovf_o);
  p_no_write_when_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CW'(MEM_DEPTH)) |-> !mem_we_o);
  p_ovf_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !sreset_bit_i && !sreset_pin_i) |=> ovf_o);
  p_waddr_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !sreset_bit_i && !sreset_pin_i) |=>
      (mem_waddr_o == (($past(mem_waddr_o) == AW'(MEM_DEPTH - 1)) ? '0 : $past(mem_waddr_o) + 1'b1)));
  p_rd_valid_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_valid_o) |-> $past(rd_en_i));
  p_unsync_no_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_ok_i && !wr_all_i) |-> !mem_we_o);
endmodule

// File: tb/tb_sbb_top.sv
`timescale 1ns/1ps
module tb_sbb_top;
  localparam int DW = 16;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          blk_valid = 1'b0;
  logic [DW-1:0] blk_data = '0;
  logic          sync_ok = 1'b0, sres_bit = 1'b0, sres_pin = 1'b0, wr_all = 1'b0;
  logic [1:0]    thr_sel = 2'b00;
  logic          rd_en = 1'b0;
  logic          mem_we, rd_valid, ready_n, ovf;
  logic [AW-1:0] mem_waddr;
  logic [DW-1:0] mem_wdata, rd_data;
  int            n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  sbb_top dut (
    .clk_i(clk), .rst_ni(rst_n), .blk_valid_i(blk_valid), .blk_data_i(blk_data),
    .sync_ok_i(sync_ok), .sreset_bit_i(sres_bit), .sreset_pin_i(sres_pin),
    .wr_all_i(wr_all), .thr_sel_i(thr_sel), .rd_en_i(rd_en),
    .mem_we_o(mem_we), .mem_waddr_o(mem_waddr), .mem_wdata_o(mem_wdata),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .ready_n_o(ready_n), .ovf_o(ovf)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); #1; endtask
  task automatic idle(); blk_valid = 1'b0; rd_en = 1'b0; endtask
  task automatic put(input logic [DW-1:0] d); blk_valid = 1'b1; blk_data = d; endtask

  task automatic pin_reset();
    idle(); sres_pin = 1'b1; tick(); tick(); sres_pin = 1'b0; #1;
  endtask

  task automatic t_reset_r1();
    chk(ready_n == 1'b1, "R1 ready_n", ready_n, 1);
    chk(mem_we == 1'b0, "R1 mem_we", mem_we, 0);
    chk(ovf == 1'b0, "R1 ovf", ovf, 0);
    chk(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
  endtask

  task automatic t_backward_r4_r5();
    logic [DW-1:0] exp_d [3];
    exp_d = '{16'hA2, 16'hA3, 16'hA4};
    wr_all = 1'b0; sync_ok = 1'b0; pin_reset();
    for (int i = 1; i <= 3; i++) begin
      put(DW'(16'hA0 + i)); #1;
      chk(mem_we == 1'b0, "R4 unsync write", mem_we, 0);
      tick();
    end
    sync_ok = 1'b1; put(16'hA4);
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(mem_we == 1'b1, "R5 drain we", mem_we, 1);
      chk(mem_wdata == exp_d[i], "R5 drain order", mem_wdata, exp_d[i]);
      chk(mem_waddr == AW'(i), "R2 waddr from 0", mem_waddr, i);
      tick(); blk_valid = 1'b0;
    end
    #1; chk(mem_we == 1'b0, "R5 drain done", mem_we, 0);
    rd_en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(rd_valid == 1'b1, "R8 rd_valid", rd_valid, 1);
      chk(rd_data == exp_d[i], "R8 rd_data", rd_data, exp_d[i]);
    end
    rd_en = 1'b0; tick();
    rd_en = 1'b1; tick(); rd_en = 1'b0;
    chk(rd_valid == 1'b0, "R8 empty read", rd_valid, 0);
  endtask

  task automatic t_release_r3();
    sync_ok = 1'b1; wr_all = 1'b0; sres_bit = 1'b1; put(16'h0B1); #1;
    chk(mem_we == 1'b0, "R3 held reset", mem_we, 0);
    tick(); sres_bit = 1'b0; put(16'h0B2); #1;
    chk(mem_we == 1'b1, "R3 first after release", mem_we, 1);
    chk(mem_wdata == 16'h0B2, "R3 data", mem_wdata, 16'h0B2);
    chk(mem_waddr == '0, "R3 waddr", mem_waddr, 0);
    tick(); idle(); #1;
    chk(ready_n == 1'b0, "R7 thr 1 reached", ready_n, 0);
  endtask

  task automatic t_wr_all_r6();
    sync_ok = 1'b0; wr_all = 1'b1; pin_reset();
    put(16'h0C1); #1;
    chk(mem_we == 1'b1 && mem_wdata == 16'h0C1, "R6 unsync written", mem_we, 1);
    tick();
    sres_pin = 1'b1; put(16'h0C2); #1;
    chk(mem_we == 1'b0, "R2 pin blocks write", mem_we, 0);
    tick(); sres_pin = 1'b0; idle(); #1;
    chk(ready_n == 1'b1, "R2 count cleared", ready_n, 1);
    wr_all = 1'b0;
  endtask

  task automatic t_thresh_r7();
    int thr [4];
    thr = '{1, 4, 8, 12};
    sync_ok = 1'b1;
    for (int s = 0; s < 4; s++) begin
      thr_sel = 2'(s); pin_reset();
      for (int k = 0; k < thr[s] - 1; k++) begin put(DW'(k)); tick(); end
      idle(); #1;
      chk(ready_n == 1'b1, "R7 below thr", ready_n, 1);
      put(16'h0EE); tick(); idle(); #1;
      chk(ready_n == 1'b0, "R7 at thr", ready_n, 0);
      rd_en = 1'b1; tick(); rd_en = 1'b0; #1;
      chk(ready_n == 1'b1, "R8 read lifts ready", ready_n, 1);
    end
    thr_sel = 2'b00;
  endtask

  task automatic t_full_r9_r10();
    sync_ok = 1'b1; pin_reset();
    for (int k = 0; k < 16; k++) begin put(DW'(16'h100 + k)); tick(); end
    chk(ovf == 1'b0, "R9 no ovf at full", ovf, 0);
    put(16'h0999); #1;
    chk(mem_we == 1'b0, "R9 full drop", mem_we, 0);
    tick(); idle(); #1;
    chk(ovf == 1'b1, "R9 ovf set", ovf, 1);
    rd_en = 1'b1; tick(); rd_en = 1'b0; #1;
    chk(rd_data == 16'h100, "R8 oldest first", rd_data, 16'h100);
    chk(ovf == 1'b1, "R9 ovf sticky", ovf, 1);
    put(16'h200); #1;
    chk(mem_we == 1'b1 && mem_waddr == '0, "R10 wrap to 0", mem_waddr, 0);
    tick(); idle();
    sres_bit = 1'b1; tick(); sres_bit = 1'b0; #1;
    chk(ovf == 1'b0, "R2 ovf cleared", ovf, 0);
    chk(ready_n == 1'b1, "R2 ready after reset", ready_n, 1);
  endtask

  initial begin
    #1;
    t_reset_r1();
    repeat (3) @(negedge clk);
    rst_n = 1'b1; #1;
    t_reset_r1();
    tick();
    t_backward_r4_r5();
    t_release_r3();
    t_wr_all_r6();
    t_thresh_r7();
    t_full_r9_r10();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1600000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule